// File: doc/BRIEF.md
# Run-Time Selectable CIC Decimator

This block is the first rate-reduction stage behind a third-order multibit sigma-delta modulator. It accepts signed 4-bit codes, qualified by a valid strobe, and runs them through a fourth-order cascaded integrator-comb filter. It then emits one 16-bit result for every R accepted codes. Two further decimate-by-two stages follow it downstream. A CIC ratio of 8, 16, 32, 64 or 128 therefore gives an overall chain factor between 32 and 512.

The ratio is picked by a small code that is sampled during a synchronous reset. The 32-bit accumulators use two's-complement wraparound and are sized for the largest ratio. The comb result is shifted right by an amount that depends on the ratio, so a constant input yields the same output word at every setting. The DC gain is 4096, which is 2^12.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `outValid` = 0 and `outData` = 0. The sample counter, the integrators and the combs are all cleared.
- R2: `rateSel` is decoded as log2(R) = 3 + code for codes 0 to 4. This gives R = 8, 16, 32, 64 and 128. Codes 5, 6 and 7 select R = 128.
- R3: `rateSel` is sampled only at edges where `rst` is high. Changing it at any other time has no effect on output timing or values.
- R4: Only edges with `inValid` high and `rst` low count as accepted samples. `outValid` is high for exactly one cycle, in the cycle after the edge that accepts every R-th sample since reset.
- R5: Let x[j] be the j-th accepted sample since reset, counting from 0, and let n be the index of the sample that completes output m. The full-precision value is the sum over k of h[k]·x[n−4−k]. Here h holds the coefficients of ((1−z^−R)/(1−z^−1))^4, and samples with negative indices count as zero. The sum is taken modulo 2^32. `outData` holds its last value between output pulses.
- R6: The 16-bit output is the 32-bit result shifted right arithmetically by 4·log2(R) − 12 bits. The shift is 0 at R = 8 and 16 at R = 128, and the 16 least significant bits are kept.
- R7: After a constant input x has been applied since reset, the fifth and every later output equal x·4096. For x = 7 this is 28672 (0x7000), and for x = −8 it is −32768 (0x8000).
- R8: `inData` is two's complement, so code 0xF means −1. A constant −1 settles to −4096 (0xF000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches `rateSel` |
| inValid | input | 1 | Input sample qualifier |
| inData | input | 4 | Signed modulator code |
| rateSel | input | 3 | Ratio code, sampled during reset |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | 16 | Rate-normalised signed result |

## Verification
The registers that move the R-th accepted sample's strobe to the output are counted as follows. The result appears with `outValid` in the cycle right after that accepting edge. The comb combines an integrator value that lags its newest sample by four samples. The bench drives inputs at the falling edge and updates its behavioural model for the coming rising edge. It compares both outputs at the next falling edge, so every cycle's expectation is due exactly one edge after its stimulus. Settled-value checks for R7 and R8 are made after the last output pulse of a constant run, at a falling edge where `outData` is known to be stable.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic accept;  // sample taken into the integrators
    logic decim;   // this sample completes an output period
    logic clear;   // synchronous clear of all filter state
  } ctrlStrobes_t;

  // Map a select code onto log2 of the ratio, clamping out-of-range codes
  function automatic int unsigned decodeLog(int unsigned code, int unsigned minLog,
                                            int unsigned maxLog);
    if (code > maxLog - minLog) return maxLog;
    return minLog + code;
  endfunction

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int MIN_LOG = 3,
  parameter int MAX_LOG = 7,
  parameter int SEL_W   = 3,
  parameter int LOG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [SEL_W-1:0] rateSel,
  output ctrlStrobes_t     strobes,
  output logic [LOG_W-1:0] activeLog
);

  localparam int CNT_W = MAX_LOG;

  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             atLast;

  assign lastIdx = CNT_W'((32'd1 << activeLog) - 32'd1);
  assign atLast  = (sampleCnt == lastIdx);

  always_comb begin
    strobes.clear  = rst;
    strobes.accept = inValid & ~rst;
    strobes.decim  = inValid & ~rst & atLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      activeLog <= LOG_W'(decodeLog(int'(rateSel), MIN_LOG, MAX_LOG));
    end else if (inValid) begin
      sampleCnt <= atLast ? '0 : sampleCnt + 1'b1;
    end
  end

  // Ratio only changes under reset
  assert_rate_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(activeLog));

  // Latched ratio is always one of the legal ones
  assert_rate_range_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(activeLog) >= MIN_LOG) && (int'(activeLog) <= MAX_LOG));

  // Counter never passes the last index of the period
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    sampleCnt <= lastIdx);

endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int IN_W    = 4,
  parameter int ORDER   = 4,
  parameter int MAX_LOG = 7,
  parameter int OUT_W   = 16,
  parameter int LOG_W   = 3
) (
  input  logic                    clk,
  input  ctrlStrobes_t            strobes,
  input  logic signed [IN_W-1:0]  inData,
  input  logic [LOG_W-1:0]        activeLog,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  localparam int ACC_W = IN_W + ORDER * MAX_LOG;
  localparam int SH_W  = $clog2(ACC_W + 1);

  logic signed [ACC_W-1:0] integ   [ORDER];
  logic signed [ACC_W-1:0] combDly [ORDER];
  logic signed [ACC_W-1:0] combTap [ORDER+1];
  logic signed [ACC_W-1:0] wideIn;
  logic signed [ACC_W-1:0] scaled;
  logic [SH_W-1:0]         shiftAmt;

  assign wideIn = {{(ACC_W-IN_W){inData[IN_W-1]}}, inData};

  // Integrator cascade: each stage adds the previous stage's registered value
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      for (int k = 0; k < ORDER; k++) integ[k] <= '0;
    end else if (strobes.accept) begin
      integ[0] <= integ[0] + wideIn;
      for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
    end
  end

  // Comb cascade evaluated combinationally at the decimated rate
  assign combTap[0] = integ[ORDER-1];
  generate
    for (genvar c = 0; c < ORDER; c++) begin : g_comb
      assign combTap[c+1] = combTap[c] - combDly[c];
      always_ff @(posedge clk) begin
        if (strobes.clear)      combDly[c] <= '0;
        else if (strobes.decim) combDly[c] <= combTap[c];
      end
    end
  endgenerate

  // Gain normalisation: keep the OUT_W most significant live bits
  assign shiftAmt = SH_W'(IN_W + ORDER * int'(activeLog) - OUT_W);
  assign scaled   = combTap[ORDER] >>> shiftAmt;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.decim;
      if (strobes.decim) outData <= scaled[OUT_W-1:0];
    end
  end

  // Reset clears the visible outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    strobes.clear |=> (!outValid && outData == '0));

  // A completed period produces a pulse on the next cycle
  assert_decim_pulse_R4: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.decim |=> outValid);

  // Pulse lasts one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (strobes.clear)
    outValid |=> !outValid);

  // Output word holds between periods
  assert_hold_R5: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.decim |=> $stable(outData));

endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int IN_W    = 4,
  parameter int ORDER   = 4,
  parameter int MIN_LOG = 3,
  parameter int MAX_LOG = 7,
  parameter int OUT_W   = 16,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic [SEL_W-1:0] rateSel,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);

  localparam int LOG_W = $clog2(MAX_LOG + 1);

  ctrlStrobes_t     strobes;
  logic [LOG_W-1:0] activeLog;

  cic_ctrl #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SEL_W(SEL_W), .LOG_W(LOG_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .rateSel(rateSel),
    .strobes(strobes), .activeLog(activeLog)
  );

  cic_datapath #(
    .IN_W(IN_W), .ORDER(ORDER), .MAX_LOG(MAX_LOG), .OUT_W(OUT_W), .LOG_W(LOG_W)
  ) i_dp (
    .clk(clk), .strobes(strobes), .inData(inData), .activeLog(activeLog),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: tb/test_cic_decim.sv
module test_cic_decim;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  inData = '0;
  logic [2:0]  rateSel = '0;
  logic        outValid;
  logic [15:0] outData;

  always #4 clk = ~clk;  // 125 MHz

  cic_decim i_cic_decim (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .rateSel(rateSel), .outValid(outValid), .outData(outData)
  );

  int          nTests = 0;
  int          nFail  = 0;
  string       curReq = "R1";
  bit          expValid = 1'b0;
  logic [15:0] expData  = '0;
  int          refLog = 3;
  int          cnt = 0;
  int          hist[$];
  longint      taps[];
  bit          done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int decodeCode(int code);
    return (code > 4) ? 7 : 3 + code;
  endfunction

  // Impulse response of four cascaded length-R boxcars
  function automatic void buildTaps(int lg);
    int     r;
    longint t[];
    r = 1 << lg;
    taps = new[1];
    taps[0] = 1;
    for (int s = 0; s < 4; s++) begin
      t = new[taps.size() + r - 1];
      foreach (t[i]) t[i] = 0;
      foreach (taps[i]) for (int j = 0; j < r; j++) t[i+j] += taps[i];
      taps = t;
    end
  endfunction

  function automatic logic [15:0] refOut();
    longint             s = 0;
    int                 n;
    logic signed [31:0] w;
    int                 sh;
    n = hist.size() - 1;
    foreach (taps[k]) begin
      int idx = n - 4 - k;
      if (idx >= 0) s += taps[k] * longint'(hist[idx]);
    end
    w  = s[31:0];
    sh = 4 * refLog - 12;
    w  = w >>> sh;
    return w[15:0];
  endfunction

  task automatic checkCycle();
    nTests++;
    if (outValid !== expValid || outData !== expData) begin
      nFail++;
      $display("FAIL %s t=%0t: valid=%b data=%h expected valid=%b data=%h",
               curReq, $time, outValid, outData, expValid, expData);
    end
  endtask

  task automatic checkVal(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: outData=%h expected %h", req, act, exp);
    end
  endtask

  // One clock: check outputs due now, drive next inputs, advance the model
  task automatic step(bit r, bit v, int d);
    @(negedge clk);
    checkCycle();
    rst     = r;
    inValid = v;
    inData  = 4'(d);
    if (r) begin
      refLog = decodeCode(int'(rateSel));
      buildTaps(refLog);
      hist.delete();
      cnt      = 0;
      expValid = 1'b0;
      expData  = '0;
    end else begin
      expValid = 1'b0;
      if (v) begin
        hist.push_back(d);
        cnt++;
        if (cnt == (1 << refLog)) begin
          cnt      = 0;
          expValid = 1'b1;
          expData  = refOut();
        end
      end
    end
  endtask

  task automatic doReset(int code);
    rateSel = 3'(code);
    step(1, 0, 0);
    step(1, 0, 0);
  endtask

  task automatic nextLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    @(negedge clk);
    doReset(0);
    step(0, 0, 0);
    step(0, 0, 0);

    // R7: constant +7 at R = 8 settles to 0x7000
    curReq = "R7";
    for (int i = 0; i < 64; i++) step(0, 1, 7);
    step(0, 0, 0);
    checkVal("R7", outData, 16'h7000);

    // R5: pseudo-random data with gaps at R = 8
    curReq = "R5";
    for (int i = 0; i < 400; i++) begin
      nextLfsr();
      step(0, lfsr[0] | lfsr[5], int'($signed(lfsr[11:8])));
    end

    // R3: select changes without reset are ignored
    curReq = "R3";
    rateSel = 3'd4;
    for (int i = 0; i < 200; i++) begin
      nextLfsr();
      step(0, 1, int'($signed(lfsr[3:0])));
    end
    rateSel = 3'd1;
    for (int i = 0; i < 50; i++) step(0, 1, 3);

    // R4: sparse valid, one sample every third cycle
    curReq = "R4";
    doReset(0);
    for (int i = 0; i < 150; i++) step(0, (i % 3) == 0, (i % 7) - 3);

    // R6: ramp at R = 32
    curReq = "R6";
    doReset(2);
    for (int i = 0; i < 400; i++) step(0, 1, (i % 16) - 8);

    // R7: constant -8 at R = 16 settles to 0x8000
    curReq = "R7";
    doReset(1);
    for (int i = 0; i < 128; i++) step(0, 1, -8);
    step(0, 0, 0);
    checkVal("R7", outData, 16'h8000);

    // R2: out-of-range code selects R = 128, then code 3 selects R = 64
    curReq = "R2";
    doReset(6);
    for (int i = 0; i < 700; i++) step(0, 1, ((i / 5) % 2 == 0) ? 6 : -5);
    doReset(3);
    for (int i = 0; i < 400; i++) begin
      nextLfsr();
      step(0, 1, int'($signed(lfsr[7:4])));
    end
    doReset(4);
    for (int i = 0; i < 640; i++) step(0, 1, 5);
    step(0, 0, 0);
    checkVal("R7", outData, 16'h5000);

    // R8: code 0xF is -1
    curReq = "R8";
    doReset(0);
    for (int i = 0; i < 64; i++) step(0, 1, -1);
    step(0, 0, 0);
    checkVal("R8", outData, 16'hF000);

    step(0, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule